// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

This block gathers interrupt events for a network controller. The transmit path, the receive path and the control logic raise one-cycle pulses. The block latches each pulse into a 32-bit event register. Software reads that register through a small register port. It acknowledges events by writing ones to the bits it wants to clear. A second 32-bit register selects which events may reach the interrupt controller. Software writes that register as a whole.

Only bits 31 down to 19 are implemented. Each of the 13 interrupt lines watches one fixed implemented bit. The line order is a fixed, non-sequential table, because the interrupt controller wires each line to its own vector. A line is high when its event bit and its enable bit are both set.

The lines are registered. The block keeps the previous active vector and toggles only the lines whose state differs from it.

Top module: `nic_irq_agg`

## Requirements
- R1: A pulse on `evt_set_i[b]`, for b in 19..31, sets event bit b. Bit b then reads back as 1 with `reg_sel_i`=0. Bit meanings:
  - 31 heartbeat
  - 30 babbling receive
  - 29 babbling transmit
  - 28 graceful stop done
  - 27 TX frame
  - 26 TX buffer
  - 25 RX frame
  - 24 RX buffer
  - 23 management done
  - 22 bus error
  - 21 late collision
  - 20 retry limit
  - 19 underrun
- R2: A write with `reg_sel_i`=0 clears every event bit whose written bit is 1. Bits written as 0 keep their value.
- R3: A write with `reg_sel_i`=1 replaces the whole enable mask with the written value ANDed with 0xFFF80000. A read with `reg_sel_i`=1 returns the mask.
- R4: Line k follows event bit P[k], where P = {27,26,19,20,25,24,23,21,31,28,22,29,30} for k = 0..12.
- R5: On the clock edge after any register state, `irq_o[k]` equals event[P[k]] AND mask[P[k]] of that state. A line changes only when its computed value changes.
- R6: A cycle with `ctl_rst_i` high clears both registers. This includes any set pulse or write in the same cycle.
- R7: If a set pulse and a write-one clear hit the same event bit in the same cycle, the bit ends up set.
- R8: Bits 18..0 of both registers always read as 0. Writes and set pulses on those bits have no effect.
- R9: After `rst_ni` is asserted, the event register, the mask register and all lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_rst_i | input | 1 | Synchronous controller reset; clears both registers |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = event, 1 = mask |
| reg_wdata_i | input | 32 | Write data |
| evt_set_i | input | 32 | One-cycle event set pulses, by bit position |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 13 | Interrupt lines, registered |

## Verification
A wrong event or mask bit shows on the read port in the cycle right after the write or pulse that caused it. It shows on the affected line one clock later.

A wrong entry in the line table only shows on a single line, and only when that line's bit is both set and enabled. The bench therefore walks every line on its own, with a one-hot mask.

A long arithmetic sequence of mixed set, clear, mask and controller-reset cycles then compares both registers and all 13 lines after every step. A lost collision or a stuck bit is therefore caught within two clocks of the step that exposes it.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int EVT_W   = 32;
  localparam int EVT_LO  = 19;
  localparam int NUM_IRQ = 13;

  // event bit positions
  localparam int B_HB   = 31;
  localparam int B_BRX  = 30;
  localparam int B_BTX  = 29;
  localparam int B_GSTP = 28;
  localparam int B_TXF  = 27;
  localparam int B_TXB  = 26;
  localparam int B_RXF  = 25;
  localparam int B_RXB  = 24;
  localparam int B_MGT  = 23;
  localparam int B_BERR = 22;
  localparam int B_LCOL = 21;
  localparam int B_RLIM = 20;
  localparam int B_UNR  = 19;

  // line index -> event bit; order is fixed by interrupt controller wiring
  function automatic int line_bit(input int k);
    case (k)
      0:       return B_TXF;
      1:       return B_TXB;
      2:       return B_UNR;
      3:       return B_RLIM;
      4:       return B_RXF;
      5:       return B_RXB;
      6:       return B_MGT;
      7:       return B_LCOL;
      8:       return B_HB;
      9:       return B_GSTP;
      10:      return B_BERR;
      11:      return B_BTX;
      12:      return B_BRX;
      default: return B_HB;
    endcase
  endfunction

  function automatic logic [EVT_W-1:0] impl_mask(input int lo);
    logic [EVT_W-1:0] m;
    for (int i = 0; i < EVT_W; i++) m[i] = (i >= lo);
    return m;
  endfunction
endpackage

// File: rtl/nic_irq_evt.sv
module nic_irq_evt #(
  parameter int                  W    = 32,
  parameter logic [W-1:0]        IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_rst_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] evt_q, evt_d, clr_m, set_m;

  assign clr_m = clr_we_i ? clr_i : '0;
  assign set_m = set_i & IMPL;

  always_comb begin
    // set applied after clear: a same-cycle pulse is never lost
    evt_d = (evt_q & ~clr_m) | set_m;
    if (ctl_rst_i) evt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rst_i |=> ((evt_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R2
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !ctl_rst_i) |=>
      ((evt_o & $past(clr_i) & ~$past(set_i)) == '0));

  // R6
  evt_ctl_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_i |=> (evt_o == '0));
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_rst_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (ctl_rst_i) mask_q <= '0;
    else if (we_i)      mask_q <= wdata_i & IMPL;
  end

  assign mask_o = mask_q;

  // R3
  mask_replace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ctl_rst_i) |=> (mask_o == ($past(wdata_i) & IMPL)));

  // R3
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !ctl_rst_i) |=> $stable(mask_o));

  // R6
  mask_ctl_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_i |=> (mask_o == '0));
endmodule

// File: rtl/nic_irq_lines.sv
module nic_irq_lines #(
  parameter int W  = 32,
  parameter int NL = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  evt_i,
  input  logic [W-1:0]  mask_i,
  output logic [NL-1:0] irq_o
);
  import nic_irq_pkg::*;

  logic [W-1:0]  active;
  logic [NL-1:0] want, irq_q, chg;

  assign active = evt_i & mask_i;

  for (genvar k = 0; k < NL; k++) begin : g_map
    assign want[k] = active[line_bit(k)];
  end

  // toggle only lines whose state moved
  assign chg = want ^ irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_q ^ chg;
  end

  assign irq_o = irq_q;

  // R5
  line_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(active) |=> $stable(irq_o));
endmodule

// File: rtl/nic_irq_agg.sv
module nic_irq_agg
  import nic_irq_pkg::*;
#(
  parameter int W  = EVT_W,
  parameter int LO = EVT_LO,
  parameter int NL = NUM_IRQ
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_rst_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [W-1:0]  reg_wdata_i,
  input  logic [W-1:0]  evt_set_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic [NL-1:0] irq_o
);
  localparam logic [W-1:0] IMPL = impl_mask(LO);

  logic [W-1:0] evt, mask;

  nic_irq_evt #(.W(W), .IMPL(IMPL)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_rst_i(ctl_rst_i),
    .clr_we_i (reg_we_i && !reg_sel_i),
    .clr_i    (reg_wdata_i),
    .set_i    (evt_set_i),
    .evt_o    (evt)
  );

  nic_irq_mask #(.W(W), .IMPL(IMPL)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_rst_i(ctl_rst_i),
    .we_i     (reg_we_i && reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .mask_o   (mask)
  );

  nic_irq_lines #(.W(W), .NL(NL)) u_lines (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .mask_i(mask),
    .irq_o (irq_o)
  );

  assign reg_rdata_o = reg_sel_i ? mask : evt;

  // R8
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt | mask) & ~IMPL) == '0);

  for (genvar k = 0; k < NL; k++) begin : g_chk
    // R4
    line_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] == $past(evt[line_bit(k)] & mask[line_bit(k)]));
  end
endmodule

// File: tb/nic_irq_agg_tb.sv
`timescale 1ns/1ps
module nic_irq_agg_tb;
  localparam logic [31:0] IMPL = 32'hFFF8_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_rst_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] evt_set_i = '0;
  logic [31:0] reg_rdata_o;
  logic [12:0] irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;
  int pos [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #2.5 clk_i = ~clk_i;

  nic_irq_agg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_rst_i(ctl_rst_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .evt_set_i(evt_set_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [12:0] exp_irq(logic [31:0] e, logic [31:0] m);
    logic [12:0] r;
    for (int k = 0; k < 13; k++) r[k] = e[pos[k]] & m[pos[k]];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    reg_sel_i = sel;
    #1;
    d = reg_rdata_o;
  endtask

  // one cycle of stimulus, then one more so the lines settle
  task automatic op(logic we, logic sel, logic [31:0] wd, logic [31:0] set, logic crst);
    @(negedge clk_i);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    evt_set_i = set; ctl_rst_i = crst;
    if (crst) begin
      m_evt = '0;
      m_mask = '0;
    end else begin
      if (we && !sel) m_evt = m_evt & ~wd;
      m_evt = m_evt | (set & IMPL);
      if (we && sel) m_mask = wd & IMPL;
    end
    @(negedge clk_i);
    reg_we_i = 0; evt_set_i = '0; ctl_rst_i = 0; reg_wdata_i = '0;
    @(negedge clk_i);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    rd(1'b0, d); check(req, d, m_evt);
    rd(1'b1, d); check(req, d, m_mask);
    check(req, {19'd0, irq_o}, {19'd0, exp_irq(m_evt, m_mask)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk_i);

    // R9 reset state
    rd(1'b0, d); check("R9", d, '0);
    rd(1'b1, d); check("R9", d, '0);
    check("R9", {19'd0, irq_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R4 R2 walk every line
    for (int k = 0; k < 13; k++) begin
      op(0, 0, 0, 32'd1 << pos[k], 0);
      rd(1'b0, d); check("R1", d, 32'd1 << pos[k]);
      check("R5", {19'd0, irq_o}, '0);
      op(1, 1, 32'd1 << pos[k], 0, 0);
      check("R4", {19'd0, irq_o}, 32'd1 << k);
      op(1, 0, 32'd1 << pos[k], 0, 0);
      rd(1'b0, d); check("R2", d, '0);
      check("R2", {19'd0, irq_o}, '0);
      op(1, 1, 0, 0, 0);
    end

    // R2 writing zeros keeps bits
    op(0, 0, 0, IMPL, 0);
    op(1, 0, 32'h0F00_0000, 0, 0);
    rd(1'b0, d); check("R2", d, 32'hF0F8_0000);

    // R3 mask replaced, not merged
    op(1, 1, 32'hAAAA_AAAA, 0, 0);
    op(1, 1, 32'h5555_5555, 0, 0);
    rd(1'b1, d); check("R3", d, 32'h5550_0000);
    check_all("R5");

    // R7 set beats clear in the same cycle
    op(0, 0, 0, IMPL, 0);
    op(1, 0, 32'hFFFF_FFFF, 32'd1 << 27, 0);
    rd(1'b0, d); check("R7", d, 32'h0800_0000);

    // R8 low bits inert
    op(1, 1, 32'hFFFF_FFFF, 0, 0);
    rd(1'b1, d); check("R8", d, 32'hFFF8_0000);
    op(0, 0, 0, 32'h0007_FFFF, 0);
    rd(1'b0, d); check("R8", d, 32'h0800_0000);

    // R6 controller reset beats pulse and write
    op(0, 0, 0, IMPL, 0);
    check_all("R5");
    op(1, 1, 32'hFFFF_FFFF, IMPL, 1);
    rd(1'b0, d); check("R6", d, '0);
    rd(1'b1, d); check("R6", d, '0);
    check("R6", {19'd0, irq_o}, '0);

    // R5 arithmetic sweep
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      op(lfsr[0], lfsr[1], {lfsr[15:2], lfsr[31:14]},
         lfsr[3] ? {lfsr[27:4], lfsr[31:24]} : '0, lfsr[7:2] == 6'd0);
      check_all("R5");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule